// File: doc/BRIEF.md
# Prescaled Time-Base Timer with Sticky Overflow

This block is the time base of a small 4-bit processor core. The core gives it one enable strobe per instruction cycle. A 2-bit divide-by-4 prescaler counts those strobes. Every fourth strobe advances an 8-bit up counter, so the combined time base is 10 bits long and repeats every 1024 instruction cycles.

Software has three ways to reach the timer:
- It can preset the counter through an 8-bit load port. Loading also clears the prescaler.
- It can read the counter value back.
- It can test and clear a sticky overflow flag. The flag is set when the counter wraps from its top value to zero. It is also set when a value with its top bit high is loaded.

An idle request puts the block into a sleeping state. Counting goes on during sleep, and the next wrap of the counter ends the sleep with a one-cycle wake pulse.

Top module: `tbase_timer`

## Requirements
- R1: When `tick` is low the prescaler does not move and `cnt_o` keeps its value. Each cycle with `tick` high advances the prescaler by one.
- R2: With no load in between, `cnt_o` increases by one on the fourth, eighth, ... tick after the prescaler was last cleared. Starting from reset, 1024 ticks bring `cnt_o` back to 0.
- R3: A cycle with `ld_stb` high writes all 8 bits of `ld_data` into the counter in that one cycle: the upper nibble is bits 7:4 and the lower nibble is bits 3:0. The same load clears the prescaler. A load wins over a tick in the same cycle.
- R4: A tick that carries the counter from 255 to 0 sets the overflow flag. The flag stays set until it is tested.
- R5: A cycle with `tst_stb` high makes `tst_hit` equal, in the next cycle, to the flag value before the strobe. The strobe also clears the flag. `tst_hit` is 0 in any cycle that does not follow a test strobe.
- R6: If a flag set (counter wrap or R7 load) and a test strobe fall in the same cycle, the test reports the old value and the flag ends up set.
- R7: A load whose `ld_data[7]` is 1 sets the overflow flag. A load with bit 7 at 0 leaves the flag as it was.
- R8: `idle_req` high makes `asleep` high from the next cycle. The counter keeps counting while `asleep` is high. The wrap to 0 clears `asleep` and drives `wake` high for exactly one cycle.
- R9: `rst` is synchronous and active high. It clears the counter, the prescaler, the flag, `asleep`, `wake` and `tst_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle instruction-cycle enable |
| ld_stb | input | 1 | Load strobe for the counter |
| ld_data | input | 8 | Load value, two nibbles |
| tst_stb | input | 1 | Test-and-clear strobe for the overflow flag |
| idle_req | input | 1 | Request to enter the sleeping state |
| cnt_o | output | 8 | Counter value |
| tst_hit | output | 1 | Flag value returned by the last test strobe |
| asleep | output | 1 | Sleeping state |
| wake | output | 1 | One-cycle pulse ending sleep on counter wrap |

## Verification
Two functions can meet in one cycle: a flag set and a test-and-clear of that flag. The set comes either from the counter wrap or from a load with bit 7 high. The bench first clears the flag. It then runs the counter to 255 with three prescaler ticks, and issues the wrapping tick in the same cycle as the test strobe. The test must return 0 and a later test must return 1. A load of 0x80 together with a test strobe is judged the same way.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  // set/clear request pair for the sticky overflow flag
  typedef struct packed {
    logic set;
    logic clr;
  } flag_req_t;
endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int PRE_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clear,
  output logic carry
);
  generate
    if (PRE_W == 0) begin : g_none
      assign carry = tick && !clear;
    end else begin : g_div
      localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};
      logic [PRE_W-1:0] pre_q;

      always_ff @(posedge clk) begin
        if (rst || clear) pre_q <= '0;
        else if (tick)    pre_q <= pre_q + 1'b1;
      end

      assign carry = tick && !clear && (pre_q == PRE_TOP);

      // R3: a load leaves the prescaler at zero
      a_r3_load_clears_pre: assert property (@(posedge clk) disable iff (rst)
        clear |=> (pre_q == '0));
      // R1: without a tick the prescaler holds
      a_r1_pre_holds: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear) |=> $stable(pre_q));
    end
  endgenerate
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             carry,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (carry) cnt_q <= cnt_q + 1'b1;
  end

  assign wrap = carry && !load && (cnt_q == CNT_TOP);

  // R1: counter stays put with neither carry nor load
  a_r1_cnt_stable: assert property (@(posedge clk) disable iff (rst)
    (!carry && !load) |=> $stable(cnt_q));
  // R2: a prescaler carry moves the counter by exactly one
  a_r2_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (carry && !load) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R3: loaded value appears whole in the next cycle
  a_r3_cnt_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/tbase_flag.sv
module tbase_flag
  import tbase_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_req_t req,
  output logic      ovf_q,
  output logic      hit_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= req.clr && ovf_q;
      if (req.set)      ovf_q <= 1'b1;
      else if (req.clr) ovf_q <= 1'b0;
    end
  end

  // R6: a set in the test cycle survives the clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    req.set |=> ovf_q);
  // R5: a test with no set leaves the flag clear
  a_r5_test_clears: assert property (@(posedge clk) disable iff (rst)
    (req.clr && !req.set) |=> !ovf_q);
  // R5: the hit reports the flag before the strobe
  a_r5_hit_value: assert property (@(posedge clk) disable iff (rst)
    req.clr |=> (hit_q == $past(ovf_q)));
  // R4: the flag is sticky without a test
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !req.clr) |=> ovf_q);
endmodule

// File: rtl/tbase_idle.sv
module tbase_idle (
  input  logic clk,
  input  logic rst,
  input  logic idle_req,
  input  logic wrap,
  output logic asleep_q,
  output logic wake_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      asleep_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      wake_q <= wrap && asleep_q;
      if (wrap)          asleep_q <= 1'b0;
      else if (idle_req) asleep_q <= 1'b1;
    end
  end

  // R8: wake only ends a real sleep and leaves the block awake
  a_r8_wake_from_sleep: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> (!asleep_q && $past(asleep_q)));
  // R8: wake lasts one cycle
  a_r8_wake_single: assert property (@(posedge clk) disable iff (rst)
    wake_q |=> !wake_q);
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbase_pkg::*;
#(
  parameter int PRE_W = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ld_stb,
  input  logic [CNT_W-1:0] ld_data,
  input  logic             tst_stb,
  input  logic             idle_req,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tst_hit,
  output logic             asleep,
  output logic             wake
);
  localparam int MSB = CNT_W - 1;

  logic      carry;
  logic      wrap;
  logic      ovf;
  flag_req_t freq;

  tbase_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .tick(tick), .clear(ld_stb), .carry(carry)
  );

  tbase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .carry(carry), .load(ld_stb),
    .load_val(ld_data), .cnt_q(cnt_o), .wrap(wrap)
  );

  assign freq.set = wrap || (ld_stb && ld_data[MSB]);
  assign freq.clr = tst_stb;

  tbase_flag u_flag (
    .clk(clk), .rst(rst), .req(freq), .ovf_q(ovf), .hit_q(tst_hit)
  );

  tbase_idle u_idle (
    .clk(clk), .rst(rst), .idle_req(idle_req), .wrap(wrap),
    .asleep_q(asleep), .wake_q(wake)
  );

  // R7: a load with the top bit high leaves the flag set
  a_r7_msb_load_sets: assert property (@(posedge clk) disable iff (rst)
    (ld_stb && ld_data[MSB]) |=> ovf);
  // R4: counter reaching zero by counting sets the flag
  a_r4_wrap_sets: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_o) != '0 && cnt_o == '0 && !$past(ld_stb)) |-> ovf);
  // R9: reset clears outputs
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (cnt_o == '0 && !tst_hit && !asleep && !wake && !ovf));
endmodule

// File: tb/tbase_timer_tb.sv
module tbase_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       ld_stb = 1'b0;
  logic [7:0] ld_data = 8'h00;
  logic       tst_stb = 1'b0;
  logic       idle_req = 1'b0;
  logic [7:0] cnt_o;
  logic       tst_hit;
  logic       asleep;
  logic       wake;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tbase_timer u_dut (
    .clk(clk), .rst(rst), .tick(tick), .ld_stb(ld_stb), .ld_data(ld_data),
    .tst_stb(tst_stb), .idle_req(idle_req), .cnt_o(cnt_o), .tst_hit(tst_hit),
    .asleep(asleep), .wake(wake)
  );

  // {load value, tick count, expected count, expected flag}
  localparam logic [24:0] VEC [7] = '{
    {8'h10, 8'd4,  8'h11, 1'b0},
    {8'h20, 8'd3,  8'h20, 1'b0},
    {8'h7F, 8'd8,  8'h81, 1'b0},
    {8'hA0, 8'd0,  8'hA0, 1'b1},
    {8'hFF, 8'd4,  8'h00, 1'b1},
    {8'h05, 8'd13, 8'h08, 1'b0},
    {8'hFE, 8'd8,  8'h00, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load(input logic [7:0] v);
    ld_stb = 1'b1; ld_data = v;
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic test_flag(output logic hit);
    tst_stb = 1'b1;
    @(negedge clk);
    tst_stb = 1'b0;
    hit = tst_hit;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic h;
    @(negedge clk);
    do_reset();
    // R9 reset state
    check("R9 cnt", cnt_o, 0);
    check("R9 asleep", asleep, 0);
    check("R9 wake", wake, 0);
    check("R9 hit", tst_hit, 0);
    test_flag(h); check("R9 flag", h, 0);

    // R3 R7 R5 R2 vector table
    for (int i = 0; i < 7; i++) begin
      load(VEC[i][24:17]);
      ticks(int'(VEC[i][16:9]));
      check("R3/R2 vector count", cnt_o, int'(VEC[i][8:1]));
      test_flag(h); check("R7/R4 vector flag", h, int'(VEC[i][0]));
      test_flag(h); check("R5 flag cleared", h, 0);
    end

    // R1 no tick no change
    load(8'h33);
    repeat (10) @(negedge clk);
    check("R1 hold", cnt_o, 8'h33);
    check("R5 hit idle", tst_hit, 0);

    // R2 full period from reset
    do_reset();
    ticks(1023);
    check("R2 cnt 255", cnt_o, 255);
    test_flag(h); check("R4 no flag yet", h, 0);
    ticks(1);
    check("R2 wrap", cnt_o, 0);
    test_flag(h); check("R4 wrap flag", h, 1);

    // R3 prescaler cleared by load
    ticks(3);
    load(8'h10);
    ticks(3);
    check("R3 pre cleared", cnt_o, 8'h10);
    ticks(1);
    check("R3 step after load", cnt_o, 8'h11);

    // R3 load beats tick
    ticks(3);
    tick = 1'b1; load(8'h44); tick = 1'b0;
    check("R3 load over tick", cnt_o, 8'h44);

    // R7 load without msb leaves flag clear
    test_flag(h);
    load(8'h7E);
    test_flag(h); check("R7 msb clear", h, 0);

    // R6 wrap and test in one cycle
    load(8'hFF);
    test_flag(h);
    ticks(3);
    tick = 1'b1; test_flag(h); tick = 1'b0;
    check("R6 old value", h, 0);
    check("R6 cnt", cnt_o, 0);
    test_flag(h); check("R6 set kept", h, 1);

    // R6 msb load and test in one cycle
    ld_stb = 1'b1; ld_data = 8'h80; tst_stb = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0; tst_stb = 1'b0;
    check("R6 load+test old", tst_hit, 0);
    test_flag(h); check("R6 load set kept", h, 1);

    // R8 idle, keep counting, wake on wrap
    load(8'hFB);
    test_flag(h);
    idle_req = 1'b1; @(negedge clk); idle_req = 1'b0;
    check("R8 asleep", asleep, 1);
    ticks(16);
    check("R8 counts in idle", cnt_o, 8'hFF);
    check("R8 still asleep", asleep, 1);
    check("R8 no wake yet", wake, 0);
    ticks(4);
    check("R8 wake", wake, 1);
    check("R8 awake", asleep, 0);
    check("R8 cnt 0", cnt_o, 0);
    @(negedge clk);
    check("R8 wake one cycle", wake, 0);

    // R9 reset mid-run
    ticks(2);
    load(8'hC0);
    do_reset();
    check("R9 cnt cleared", cnt_o, 0);
    ticks(3);
    check("R9 pre cleared", cnt_o, 0);
    ticks(1);
    check("R9 count resumes", cnt_o, 1);
    test_flag(h); check("R9 flag cleared", h, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule